// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that software must service at regular intervals. A down counter is decremented by one of four prescaled taps of the system clock. When the counter passes zero, the block reports an overflow. Software holds the overflow off by writing a restart command before the counter reaches zero. The restart reloads the counter. The upper four bits of the reload value come from a configuration field, and the lower bits are always ones.

Each overflow can raise any combination of three actions: a one-cycle reset request to the system reset logic, a one-cycle interrupt pulse, and an active-low external overflow pin held low for a fixed number of system-clock cycles. A sticky status flag records the overflow until software reads it. A register write is accepted only if the same write carries the key that belongs to that register. A write with a wrong key has no effect.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, the reset request and the interrupt are low, the overflow pin is high, and reads of the mode (address 0), clock (address 1) and status (address 3) registers all return zero.
- R2: A write to address 0 is accepted only when wdata[15:4] is 0x234. The payload bits are: bit 0 run, bit 1 reset enable, bit 2 interrupt enable, bit 3 external-pin enable. A write with any other key leaves the register unchanged, and the register reads back the same value as before.
- R3: A write to address 1 is accepted only when wdata[15:6] is 0x370. The payload bits are: bits 5:2 reload preset, bits 1:0 clock select. The register reads back as {preset, select} in bits 5:0.
- R4: A write of exactly 0xC071 to address 2 reloads the counter and clears the prescaler, so the next overflow comes one full timeout after that write. A write of any other value to address 2 has no effect.
- R5: The reload value is {preset, all ones}. From an arming write (run set, or a keyed restart) to the first overflow output, the time is (preset+1) x 2^(CNT_W-4) x (clock divisor) system cycles.
- R6: Clock select values 0, 1, 2 and 3 pick the divisors 2^DIV_LOG[0] to 2^DIV_LOG[3]. The defaults give 8, 32, 128 and 1024.
- R7: While run is clear, the counter holds its reload value, the prescaler is held in reset, and no overflow occurs.
- R8: On overflow with reset enable set, the reset request is high for exactly one cycle.
- R9: On overflow with interrupt enable set, the interrupt output is high for exactly one cycle.
- R10: On overflow with external-pin enable set, the overflow pin goes low for exactly EXT_LEN (default 8) system-clock cycles.
- R11: An overflow sets the status flag (address 3, bit 0). A read of address 3 clears the flag. If an overflow and a read fall in the same cycle, the overflow wins.
- R12: The three overflow actions are independent, and each action appears only in the cycle that follows an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the status flag when it reads address 3) |
| addr | input | 2 | Register address: 0 mode, 1 clock, 2 restart, 3 status |
| wdata | input | 16 | Write data, key bits included |
| rdata | output | 16 | Read data for addr, combinational |
| wd_reset_o | output | 1 | One-cycle reset request |
| wd_irq_o | output | 1 | One-cycle interrupt pulse |
| wd_ovf_n_o | output | 1 | Active-low external overflow pin |

## Verification
The bench builds the block with CNT_W=8 and DIV_LOG set to 1, 2, 3 and 4. This shrinks the longest timeout to 4096 cycles, so every clock select and the largest preset can be timed to the exact cycle. The external pulse length stays at its default of 8. The short timeouts also make it cheap to restart mid-count at an odd prescaler phase. They also allow bad-key writes to be followed by a wait longer than a full timeout.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
   localparam int DATA_W   = 16;
   localparam int PRESET_W = 4;

   localparam logic [1:0] A_MODE    = 2'd0;
   localparam logic [1:0] A_CLK     = 2'd1;
   localparam logic [1:0] A_RESTART = 2'd2;
   localparam logic [1:0] A_STAT    = 2'd3;

   localparam logic [11:0] KEY_MODE    = 12'h234;
   localparam logic [9:0]  KEY_CLK     = 10'h370;
   localparam logic [15:0] KEY_RESTART = 16'hC071;

   typedef struct packed {
      logic ext_en;
      logic irq_en;
      logic rst_en;
      logic run;
   } mode_t;

   typedef struct packed {
      logic [PRESET_W-1:0] preset;
      logic [1:0]          sel;
   } clkcfg_t;
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
   import wdog_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ovf_evt,
   output mode_t             mode,
   output clkcfg_t           clkcfg,
   output logic              restart,
   output logic              flag,
   output logic [DATA_W-1:0] rdata
);
   logic mode_ok, clk_ok, stat_rd;

   // each write is gated by the key of its own register
   assign mode_ok = wr_en && (addr == A_MODE) && (wdata[15:4] == KEY_MODE);
   assign clk_ok  = wr_en && (addr == A_CLK)  && (wdata[15:6] == KEY_CLK);
   assign restart = wr_en && (addr == A_RESTART) && (wdata == KEY_RESTART);
   assign stat_rd = rd_en && (addr == A_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= '0;
         clkcfg <= '0;
         flag   <= 1'b0;
      end else begin
         if (mode_ok) mode   <= mode_t'(wdata[3:0]);
         if (clk_ok)  clkcfg <= clkcfg_t'(wdata[5:0]);
         if (ovf_evt)      flag <= 1'b1;
         else if (stat_rd) flag <= 1'b0;
      end
   end

   always_comb begin
      case (addr)
         A_MODE:  rdata = {12'b0, mode};
         A_CLK:   rdata = {10'b0, clkcfg};
         A_STAT:  rdata = {15'b0, flag};
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdog_prescaler.sv
`timescale 1ns/1ps
module wdog_prescaler #(
   parameter int DIV_LOG [4] = '{3, 5, 7, 10}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       clear,
   input  logic [1:0] sel,
   output logic       tick
);
   localparam int PW = DIV_LOG[3];

   logic [PW-1:0] pre;
   logic [3:0]    tap;

   for (genvar g = 0; g < 4; g++) begin : g_tap
      if (DIV_LOG[g] < 1) begin : g_bad
         $error("wdog_prescaler: divider exponent below 1");
      end
      if (g > 0) begin : g_ord
         if (DIV_LOG[g] <= DIV_LOG[g-1]) begin : g_bad_ord
            $error("wdog_prescaler: divider exponents must increase");
         end
      end
      assign tap[g] = &pre[DIV_LOG[g]-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pre <= '0;
      else if (!run || clear)  pre <= '0;
      else                     pre <= pre + 1'b1;
   end

   assign tick = run & tap[sel];
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter
   import wdog_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                restart,
   input  logic                tick,
   input  logic [PRESET_W-1:0] preset,
   output logic                ovf_evt
);
   localparam int LOW_W = CNT_W - PRESET_W;

   logic [CNT_W-1:0] cnt, reload;

   assign reload  = {preset, {LOW_W{1'b1}}};
   assign ovf_evt = run && tick && !restart && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= {{PRESET_W{1'b0}}, {LOW_W{1'b1}}};
      else if (!run || restart)  cnt <= reload;
      else if (tick)             cnt <= (cnt == '0) ? reload : cnt - 1'b1;
   end
endmodule

// File: rtl/wdog_ovf_out.sv
`timescale 1ns/1ps
module wdog_ovf_out
   import wdog_pkg::*;
#(
   parameter int EXT_LEN = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ovf_evt,
   input  mode_t mode,
   output logic  rst_o,
   output logic  irq_o,
   output logic  ovf_n_o
);
   localparam int EW = $clog2(EXT_LEN + 1);

   logic [EW-1:0] ext_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_o   <= 1'b0;
         irq_o   <= 1'b0;
         ext_cnt <= '0;
      end else begin
         rst_o <= ovf_evt && mode.rst_en;
         irq_o <= ovf_evt && mode.irq_en;
         if (ovf_evt && mode.ext_en) ext_cnt <= EW'(EXT_LEN);
         else if (ext_cnt != '0)     ext_cnt <= ext_cnt - 1'b1;
      end
   end

   assign ovf_n_o = (ext_cnt == '0);
endmodule

// File: rtl/wdog_keyed.sv
`timescale 1ns/1ps
module wdog_keyed
   import wdog_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DIV_LOG [4] = '{3, 5, 7, 10},
   parameter int EXT_LEN     = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [1:0]  addr,
   input  logic [15:0] wdata,
   output logic [15:0] rdata,
   output logic        wd_reset_o,
   output logic        wd_irq_o,
   output logic        wd_ovf_n_o
);
   if (CNT_W <= PRESET_W || CNT_W > 32) begin : g_bad_w
      $error("wdog_keyed: CNT_W must lie in PRESET_W+1..32");
   end
   if (EXT_LEN < 1) begin : g_bad_ext
      $error("wdog_keyed: EXT_LEN must be at least 1");
   end

   mode_t   mode;
   clkcfg_t clkcfg;
   logic    restart, flag, tick, ovf_evt, run_en;

   assign run_en = mode.run;

   wdog_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .ovf_evt(ovf_evt), .mode(mode), .clkcfg(clkcfg),
      .restart(restart), .flag(flag), .rdata(rdata)
   );

   wdog_prescaler #(.DIV_LOG(DIV_LOG)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_en), .clear(restart),
      .sel(clkcfg.sel), .tick(tick)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run_en), .restart(restart),
      .tick(tick), .preset(clkcfg.preset), .ovf_evt(ovf_evt)
   );

   wdog_ovf_out #(.EXT_LEN(EXT_LEN)) u_out (
      .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .mode(mode),
      .rst_o(wd_reset_o), .irq_o(wd_irq_o), .ovf_n_o(wd_ovf_n_o)
   );
endmodule

// File: rtl/wdog_keyed_chk.sv
`timescale 1ns/1ps
module wdog_keyed_chk #(
   parameter int EXT_LEN = 8
) (
   input logic clk,
   input logic rst_n,
   input logic ovf_evt,
   input logic run_en,
   input logic flag,
   input logic irq,
   input logic rst_o,
   input logic ovf_n
);
   logic [15:0] lowrun;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lowrun <= '0;
      else if (ovf_n) lowrun <= '0;
      else            lowrun <= lowrun + 1'b1;
   end

   a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   a_r8_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o |=> !rst_o);
   a_r12_irq_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(ovf_evt));
   a_r12_rst_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o |-> $past(ovf_evt));
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && $past(!run_en)) |-> (!irq && !rst_o));
   a_r11_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> flag);
   a_r10_ext_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_n) |-> (lowrun == 16'(EXT_LEN)));
   a_r10_ext_bound: assert property (@(posedge clk) disable iff (!rst_n)
      lowrun <= 16'(EXT_LEN));
endmodule

bind wdog_keyed wdog_keyed_chk #(.EXT_LEN(EXT_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .run_en(run_en),
   .flag(flag), .irq(wd_irq_o), .rst_o(wd_reset_o), .ovf_n(wd_ovf_n_o)
);

// File: tb/wdog_keyed_test.sv
`timescale 1ns/1ps
module wdog_keyed_test;
   localparam int CW = 8;
   localparam int DL [4] = '{1, 2, 3, 4};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        wd_reset_o, wd_irq_o, wd_ovf_n_o;

   always #2.5 clk = ~clk;

   wdog_keyed #(.CNT_W(CW), .DIV_LOG(DL), .EXT_LEN(8)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .wd_reset_o(wd_reset_o),
      .wd_irq_o(wd_irq_o), .wd_ovf_n_o(wd_ovf_n_o)
   );

   typedef struct {
      string req;
      int    start;
      int    len;
      bit    irq;
      bit    rst;
      bit    ext;
   } exp_t;

   exp_t q[$];
   int   total = 0, bad = 0, cyc = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   function automatic int tmo(int sel, int preset);
      return (preset + 1) * (1 << (CW - 4)) * (1 << DL[sel]);
   endfunction

   function automatic logic [15:0] clkw(int sel, int preset);
      return 16'hDC00 | 16'(preset << 2) | 16'(sel);
   endfunction

   // driver side: push an expected overflow
   task automatic expect_ovf(string req, int len, bit i, bit r, bit e);
      exp_t x;
      x.req = req; x.start = cyc; x.len = len; x.irq = i; x.rst = r; x.ext = e;
      q.push_back(x);
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
   endtask

   // monitor: pop expected overflows as the design produces them
   bit prev_n = 1'b1, prev_irq = 1'b0, prev_rst = 1'b0;
   int lowlen = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_irq) chk("R9 irq pulse width", int'(wd_irq_o), 0);
         if (prev_rst) chk("R8 reset pulse width", int'(wd_reset_o), 0);
         if (wd_ovf_n_o && !prev_n) chk("R10 pin low width", lowlen, 8);
         if (wd_irq_o || wd_reset_o || (!wd_ovf_n_o && prev_n)) begin
            if (q.size() == 0) begin
               chk("R7 unexpected overflow", 1, 0);
            end else begin
               exp_t x;
               x = q.pop_front();
               chk(x.req, cyc - x.start, x.len);
               chk("R9 irq action", int'(wd_irq_o), int'(x.irq));
               chk("R8 reset action", int'(wd_reset_o), int'(x.rst));
               chk("R12 pin action", int'(!wd_ovf_n_o), int'(x.ext));
            end
         end
         lowlen   = wd_ovf_n_o ? 0 : lowlen + 1;
         prev_n   = wd_ovf_n_o;
         prev_irq = wd_irq_o;
         prev_rst = wd_reset_o;
      end
   end

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   task automatic run_case(string req, int sel, int preset, logic [3:0] bits,
                           bit i, bit r, bit e);
      logic [15:0] d;
      wr(2'd1, clkw(sel, preset));
      rd(2'd1, d);
      chk("R3 clock readback", int'(d), (preset << 2) | sel);
      wr(2'd0, 16'h2340 | 16'(bits) | 16'h1);
      expect_ovf(req, tmo(sel, preset), i, r, e);
      drain();
      wr(2'd0, 16'h2340);
      rd(2'd3, d);
      chk("R11 flag set", int'(d), 1);
      rd(2'd3, d);
      chk("R11 flag cleared", int'(d), 0);
   endtask

   initial begin
      logic [15:0] d;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 irq", int'(wd_irq_o), 0);
      chk("R1 reset", int'(wd_reset_o), 0);
      chk("R1 pin", int'(wd_ovf_n_o), 1);
      rd(2'd0, d); chk("R1 mode", int'(d), 0);
      rd(2'd1, d); chk("R1 clock", int'(d), 0);
      rd(2'd3, d); chk("R1 status", int'(d), 0);

      // R5 R6: every clock select, irq / reset / pin combinations (R12)
      run_case("R6 sel0 timeout", 0, 0, 4'h4, 1, 0, 0);
      run_case("R6 sel1 timeout", 1, 1, 4'h2, 0, 1, 0);
      run_case("R10 sel2 timeout", 2, 2, 4'h8, 0, 0, 1);
      run_case("R5 sel3 max preset", 3, 15, 4'hE, 1, 1, 1);

      // R4 keyed restart at odd prescaler phase
      wr(2'd1, clkw(2, 0));
      wr(2'd0, 16'h2345);
      repeat (51) @(negedge clk);
      wr(2'd2, 16'hC071);
      expect_ovf("R4 restart reloads", tmo(2, 0), 1, 0, 0);
      drain();
      wr(2'd0, 16'h2340);

      // R4 restart with wrong value ignored
      wr(2'd0, 16'h2345);
      expect_ovf("R4 bad restart ignored", tmo(2, 0), 1, 0, 0);
      repeat (51) @(negedge clk);
      wr(2'd2, 16'hC072);
      drain();
      wr(2'd0, 16'h2340);
      rd(2'd3, d);
      rd(2'd3, d);

      // R2 bad mode key
      wr(2'd0, 16'h2355);
      rd(2'd0, d); chk("R2 bad key mode unchanged", int'(d), 0);
      repeat (300) @(negedge clk);
      rd(2'd3, d); chk("R2 no overflow after bad key", int'(d), 0);

      // R3 bad clock key, old setting stays in force
      wr(2'd1, 16'hDD00);
      rd(2'd1, d); chk("R3 bad key clock unchanged", int'(d), 2);
      wr(2'd0, 16'h2345);
      expect_ovf("R3 old clock setting", tmo(2, 0), 1, 0, 0);
      drain();
      wr(2'd0, 16'h2340);
      rd(2'd3, d);

      // R7 disabled: nothing happens
      wr(2'd1, clkw(0, 0));
      repeat (200) @(negedge clk);
      rd(2'd3, d); chk("R7 idle no overflow", int'(d), 0);
      chk("R7 idle pin", int'(wd_ovf_n_o), 1);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule